// File: doc/BRIEF.md
# PTP Transmit Timestamp and Tag Unit

This unit runs beside a transmit packet stream and produces precision-time-protocol timestamps for outgoing frames. On the first beat of every packet the client presents a 2-bit operation request and a 16-bit tag. The unit records the request and tag in an 8-entry in-order queue. When that packet's start later passes the capture point, signalled by a one-cycle capture pulse, the unit samples the 80-bit system time and retires the oldest queue entry.

Two-step requests return the raw captured time with the packet's tag. One-step requests return a time advanced by a static latency offset, ready for a frame editor to insert. The timer has two readings, chosen while reset is held. In normal mode it holds 48 bits of seconds over 32 bits of nanoseconds. In transparent-clock mode it holds a correction value: 47 bits of nanoseconds above a 16-bit binary fraction.

Two sticky flags record queue misuse. One is set by a push into a full queue and the other by a capture with nothing pending. Only reset clears them.

Top module: `ptp_tx_stamp`

## Requirements
- R1: The request code is sampled when `pkt_first` is high. Code 00 and code 11 push a queue entry that returns no result: at its capture both `two_vld` and `one_vld` stay low.
- R2: Code 10 (two-step) returns a result in the cycle after its capture pulse. In that cycle `two_vld` is 1, `two_time` equals `sys_time` as sampled at the capture edge, and `res_tag` equals the tag sampled with the request.
- R3: Code 01 (one-step) with `onestep_en` high returns a result in the cycle after its capture pulse. In that cycle `one_vld` is 1, `res_tag` carries the packet's tag and `one_time` carries the adjusted time.
- R4: When `onestep_en` is low, code 01 behaves as code 00 and `one_vld` never rises.
- R5: In normal mode, `one_time` is formed as follows. The seconds are bits 79:32 and the nanoseconds are bits 31:0. `lat_adj[10:3]` nanoseconds are added to the nanoseconds field, and the three fraction bits `lat_adj[2:0]` (1/8 ns each) are dropped. A sum of 1,000,000,000 or more has 10^9 subtracted and adds one to the seconds.
- R6: In transparent-clock mode (`tc_mode` high), `one_time[62:0]` equals `sys_time[62:0]` plus `lat_adj` times 2^13, modulo 2^63. Bits 79:63 pass through unchanged.
- R7: Results come out in the order the requests were pushed, at most one per cycle, with up to 8 requests pending.
- R8: A request arriving while 8 entries are pending is dropped and sets `ovf_err`. The flag stays set until reset.
- R9: A capture pulse with no entry pending produces no result and sets `unf_err`. The flag stays set until reset.
- R10: Reset empties the queue and clears `two_vld`, `one_vld`, `ovf_err` and `unf_err`.
- R11: `two_vld` and `one_vld` are never high together, and each is high only in the cycle after a capture pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| onestep_en | input | 1 | Enables one-step requests (change only in reset) |
| tc_mode | input | 1 | Selects the transparent-clock reading of the timer (change only in reset) |
| lat_adj | input | 11 | One-step offset: bits 10:3 are ns, bits 2:0 are 1/8 ns |
| sys_time | input | 80 | System time or correction value |
| pkt_first | input | 1 | First beat of a packet; pushes a request |
| pkt_op | input | 2 | Request code, sampled with pkt_first |
| pkt_tag | input | 16 | Tag, sampled with pkt_first |
| cap_pulse | input | 1 | Packet start at the capture point; pops a request |
| two_vld | output | 1 | Two-step result valid |
| one_vld | output | 1 | One-step result valid |
| res_tag | output | 16 | Tag of the current result |
| two_time | output | 80 | Raw captured time |
| one_time | output | 80 | Latency-adjusted time |
| ovf_err | output | 1 | Sticky flag for a push into a full queue |
| unf_err | output | 1 | Sticky flag for a capture with an empty queue |

## Verification
Each result passes through exactly one register. The valid strobes, tag and both times therefore appear in the cycle after the edge that saw the capture pulse, and the error flags appear in the cycle after the offending push or capture. The bench drives inputs on falling edges and samples at the next falling edge, half a cycle after the edge that produced the result. It also checks, at the capture edge, that no result is already showing. In the back-to-back test each capture's result is checked on the falling edge where the next capture is driven.

// File: rtl/ptp_tx_stamp.sv
module ptp_tx_stamp #(
  parameter int TW      = 80,
  parameter int TAGW    = 16,
  parameter int DEPTH   = 8,
  parameter int ADJW    = 11,
  parameter int NS_W    = 32,
  parameter int TC_W    = 63,
  parameter int FRAC_W  = 16,
  parameter int ONE_SEC = 1000000000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            onestep_en,
  input  logic            tc_mode,
  input  logic [ADJW-1:0] lat_adj,
  input  logic [TW-1:0]   sys_time,
  input  logic            pkt_first,
  input  logic [1:0]      pkt_op,
  input  logic [TAGW-1:0] pkt_tag,
  input  logic            cap_pulse,
  output logic            two_vld,
  output logic            one_vld,
  output logic [TAGW-1:0] res_tag,
  output logic [TW-1:0]   two_time,
  output logic [TW-1:0]   one_time,
  output logic            ovf_err,
  output logic            unf_err
);
  localparam int PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int ADJ_FR   = 3;
  localparam int ADJ_NS_W = ADJW - ADJ_FR;
  localparam int SEC_W    = TW - NS_W;
  localparam int EW       = TAGW + 2;
  localparam logic [NS_W:0] SEC_LIM = (NS_W+1)'(ONE_SEC);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire full    = (cnt == CW'(DEPTH));
  wire empty   = (cnt == '0);
  wire do_push = pkt_first && !full;
  wire do_pop  = cap_pulse && !empty;
  wire req_one = (pkt_op == 2'b01) && onestep_en;
  wire req_two = (pkt_op == 2'b10);

  wire [EW-1:0] head = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= {req_two, req_one, pkt_tag};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  wire [NS_W:0] ns_sum = {1'b0, sys_time[NS_W-1:0]}
                       + {{(NS_W+1-ADJ_NS_W){1'b0}}, lat_adj[ADJW-1:ADJ_FR]};
  wire          ns_wrap = (ns_sum >= SEC_LIM);
  wire [NS_W:0] ns_fix  = ns_wrap ? ns_sum - SEC_LIM : ns_sum;
  wire [SEC_W-1:0] sec_fix = sys_time[TW-1:NS_W] + SEC_W'(ns_wrap);
  wire [TW-1:0] norm_adj = {sec_fix, ns_fix[NS_W-1:0]};

  wire [TC_W-1:0] corr_sum = sys_time[TC_W-1:0]
                           + (TC_W'(lat_adj) << (FRAC_W - ADJ_FR));
  wire [TW-1:0] tc_adj = {sys_time[TW-1:TC_W], corr_sum};

  always_ff @(posedge clk) begin
    if (rst) begin
      two_vld  <= 1'b0;
      one_vld  <= 1'b0;
      res_tag  <= '0;
      two_time <= '0;
      one_time <= '0;
      ovf_err  <= 1'b0;
      unf_err  <= 1'b0;
    end else begin
      two_vld <= do_pop && head[EW-1];
      one_vld <= do_pop && head[EW-2];
      if (do_pop) begin
        res_tag  <= head[TAGW-1:0];
        two_time <= sys_time;
        one_time <= tc_mode ? tc_adj : norm_adj;
      end
      if (pkt_first && full) ovf_err <= 1'b1;
      if (cap_pulse && empty) unf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/ptp_tx_stamp_chk.sv
module ptp_tx_stamp_chk #(
  parameter int TW = 80
) (
  input logic          clk,
  input logic          rst,
  input logic          onestep_en,
  input logic          cap_pulse,
  input logic [TW-1:0] sys_time,
  input logic          two_vld,
  input logic          one_vld,
  input logic [TW-1:0] two_time,
  input logic          ovf_err,
  input logic          unf_err
);
  // R11
  excl_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(two_vld && one_vld));
  // R11
  two_after_cap_chk: assert property (@(posedge clk) disable iff (rst)
    two_vld |-> $past(cap_pulse));
  // R11
  one_after_cap_chk: assert property (@(posedge clk) disable iff (rst)
    one_vld |-> $past(cap_pulse));
  // R4
  one_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    one_vld |-> onestep_en);
  // R2
  two_time_chk: assert property (@(posedge clk) disable iff (rst)
    two_vld |-> two_time == $past(sys_time));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);
  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unf_err |=> unf_err);
  // R9
  unf_no_result_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unf_err) |-> !(two_vld || one_vld));
endmodule

bind ptp_tx_stamp ptp_tx_stamp_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .onestep_en(onestep_en), .cap_pulse(cap_pulse),
  .sys_time(sys_time), .two_vld(two_vld), .one_vld(one_vld),
  .two_time(two_time), .ovf_err(ovf_err), .unf_err(unf_err)
);

// File: tb/ptp_tx_stamp_test.sv
module ptp_tx_stamp_test;
  logic        clk = 0, rst = 1, onestep_en = 1, tc_mode = 0;
  logic [10:0] lat_adj = 11'd173;
  logic [79:0] sys_time = '0;
  logic        pkt_first = 0, cap_pulse = 0;
  logic [1:0]  pkt_op = '0;
  logic [15:0] pkt_tag = '0;
  logic        two_vld, one_vld, ovf_err, unf_err;
  logic [15:0] res_tag;
  logic [79:0] two_time, one_time;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ptp_tx_stamp uut (.*);

  // {op, tag, seconds, nanoseconds}
  localparam logic [97:0] VEC [8] = '{
    {2'b10, 16'h1111, 48'd5,              32'd100},
    {2'b01, 16'h2222, 48'd7,              32'd999_999_990},
    {2'b00, 16'h3333, 48'd9,              32'd5},
    {2'b11, 16'h4444, 48'd9,              32'd6},
    {2'b01, 16'h5555, 48'hFFFF_0000_0001, 32'd999_999_979},
    {2'b01, 16'h6666, 48'd12,             32'd999_999_978},
    {2'b10, 16'h7777, 48'hFFFF_FFFF_FFFF, 32'd999_999_999},
    {2'b01, 16'h8888, 48'd20,             32'd0}
  };

  function automatic logic [79:0] want_one(logic [79:0] t, bit tc);
    longint unsigned n;
    logic [47:0] s;
    logic [62:0] c;
    if (tc) begin
      c = t[62:0] + 63'(lat_adj) * 63'd8192;
      return {t[79:63], c};
    end
    n = longint'(t[31:0]) + longint'(lat_adj / 8);
    s = t[79:32];
    if (n >= 64'd1_000_000_000) begin
      n = n - 64'd1_000_000_000;
      s = s + 48'd1;
    end
    return {s, n[31:0]};
  endfunction

  task automatic chk(input string r, input logic [79:0] a, input logic [79:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", r, a, e);
    end
  endtask

  task automatic do_reset(input bit tc, input bit en);
    @(negedge clk);
    rst = 1; tc_mode = tc; onestep_en = en;
    pkt_first = 0; cap_pulse = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic run_pkt(input logic [1:0] op, input logic [15:0] tg,
                         input logic [79:0] t);
    bit e2, e1;
    string r;
    e2 = (op == 2'b10);
    e1 = (op == 2'b01) && onestep_en;
    r  = e2 ? "R2" : (e1 ? (tc_mode ? "R6" : "R5") : (op == 2'b01 ? "R4" : "R1"));
    @(negedge clk);
    pkt_first = 1; pkt_op = op; pkt_tag = tg;
    @(negedge clk);
    pkt_first = 0; pkt_tag = 16'hDEAD;
    chk("R11 idle before capture", {78'd0, two_vld, one_vld}, 80'd0);
    cap_pulse = 1; sys_time = t;
    @(negedge clk);
    cap_pulse = 0; sys_time = t + 80'd77;
    chk({r, " two_vld"}, 80'(two_vld), 80'(e2));
    chk({r, (e1 ? " R3" : ""), " one_vld"}, 80'(one_vld), 80'(e1));
    if (e2) begin
      chk("R2 tag", 80'(res_tag), 80'(tg));
      chk("R2 time", two_time, t);
    end
    if (e1) begin
      chk("R3 tag", 80'(res_tag), 80'(tg));
      chk({r, " adjusted time"}, one_time, want_one(t, tc_mode));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    do_reset(0, 1);
    @(negedge clk);
    chk("R10 reset outputs", {76'd0, two_vld, one_vld, ovf_err, unf_err}, 80'd0);

    for (int i = 0; i < 8; i++)
      run_pkt(VEC[i][97:96], VEC[i][95:80], VEC[i][79:0]);

    do_reset(0, 0);
    run_pkt(2'b01, 16'hABCD, {48'd3, 32'd50});
    run_pkt(2'b10, 16'hABCE, {48'd3, 32'd60});

    do_reset(1, 1);
    run_pkt(2'b01, 16'hC001, {17'h1_2345, 47'd1000, 16'hF000});
    run_pkt(2'b01, 16'hC002, {17'h0_0F0F, {63{1'b1}}});
    run_pkt(2'b10, 16'hC003, {17'h0_0001, 47'd5, 16'h8000});

    do_reset(0, 1);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      pkt_first = 1; pkt_op = (i % 2 == 0) ? 2'b10 : 2'b01;
      pkt_tag = 16'hA000 + 16'(i);
    end
    @(negedge clk);
    pkt_first = 0;
    chk("R8 overflow flag", 80'(ovf_err), 80'd1);
    chk("R9 no underflow yet", 80'(unf_err), 80'd0);
    for (int i = 0; i <= 8; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R7 order tag", 80'(res_tag), 80'(16'hA000 + 16'(i-1)));
        chk("R7 two_vld kind", 80'(two_vld), 80'((i-1) % 2 == 0));
        chk("R7 one_vld kind", 80'(one_vld), 80'((i-1) % 2 == 1));
        if ((i-1) % 2 == 0) chk("R7 two time", two_time, {48'd40, 32'(i-1)});
        else chk("R7 one time", one_time, want_one({48'd40, 32'(i-1)}, 0));
      end
      if (i < 8) begin
        cap_pulse = 1; sys_time = {48'd40, 32'(i)};
      end else cap_pulse = 0;
    end
    chk("R9 flag clear before empty capture", 80'(unf_err), 80'd0);
    cap_pulse = 1;
    @(negedge clk);
    cap_pulse = 0;
    chk("R9 underflow flag", 80'(unf_err), 80'd1);
    chk("R9 no result on empty capture", {78'd0, two_vld, one_vld}, 80'd0);
    repeat (3) @(negedge clk);
    chk("R8 overflow sticky", 80'(ovf_err), 80'd1);
    chk("R9 underflow sticky", 80'(unf_err), 80'd1);

    do_reset(0, 1);
    @(negedge clk);
    chk("R10 flags cleared", {78'd0, ovf_err, unf_err}, 80'd0);
    cap_pulse = 1;
    @(negedge clk);
    cap_pulse = 0;
    chk("R10 queue emptied by reset", 80'(unf_err), 80'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule